// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

This block is a 32-pin general-purpose I/O port reached through a small word-addressed register bus. Software sets each pin's direction and output level. Pad inputs pass through a two-flop synchroniser before any logic looks at them. Each pin has its own sensitivity, chosen from low level, high level, rising edge, falling edge or both edges. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. A single registered interrupt line is high while any pending status bit is also enabled in the mask.

The sensitivity of a pin comes from a 2-bit code. Pins 0 to 15 hold their codes in one configuration word and pins 16 to 31 hold theirs in a second word. A separate per-pin bit overrides the code and makes the pin respond to any edge. Level-sensitive pins set their status bit again on every cycle that the level persists, so a clear sticks only after the level has gone away.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every register reads 0, pad_out and pad_oe are 0 and irq is 0.
- R2: pad_out bit n equals bit n of the output data word, and pad_oe bit n equals bit n of the direction word, where 1 means output and 0 means input.
- R3: Word addresses decode as follows: 0 output data, 1 direction, 2 synchronised pad inputs, 3 low configuration, 4 high configuration, 5 mask, 6 status, 7 both-edge select. A write to 0, 1, 3, 4, 5 or 7 is read back unchanged.
- R4: The code of pin n sits at bits [2n+1:2n] of the low configuration word for n below 16, and at bits [2(n-16)+1:2(n-16)] of the high word otherwise. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: A level-sensitive pin sets its status bit on every cycle that its synchronised input holds the selected level.
- R6: An edge is found by comparing the synchronised input with its value one cycle earlier. A pad change therefore sets status on the third rising clock edge after it, and an edge of the opposite polarity sets nothing.
- R7: When bit n of the both-edge select word is 1, pin n sets status on rising and on falling edges, whatever its code.
- R8: Writing 1 to a status bit clears it, writing 0 leaves it alone, and an event on the same pin in the same cycle keeps the bit set.
- R9: irq is a register that takes the OR over all pins of status AND mask, so it follows them one cycle later. Masked pins still set status.
- R10: Address 2 shows the pad inputs two cycles after they change, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a new event on the same pin, because the synchroniser puts three cycles between a pad change and the status update. The bench reaches it by holding a pin at its selected level, so an event occurs on every cycle, and then issuing the clear, which must leave the bit set. A long random phase adds sparse pad toggles and random register writes, including clears and writes to the read-only word. A behavioural model compares every output and the read data for the current address on every cycle, so clears that meet edge events are also covered.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int HALF = NPIN / 2;
  localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_BOTH = 3'd7;

  logic [NPIN-1:0] data_q, dir_q, clo_q, chi_q, mask_q, stat_q, both_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q, evt, clr;
  logic wr;

  assign wr  = bus_sel & bus_we;
  assign clr = (wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; dir_q <= '0; clo_q <= '0; chi_q <= '0;
      mask_q <= '0; both_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_DATA: data_q <= bus_wdata;
        A_DIR:  dir_q  <= bus_wdata;
        A_CLO:  clo_q  <= bus_wdata;
        A_CHI:  chi_q  <= bus_wdata;
        A_MASK: mask_q <= bus_wdata;
        A_BOTH: both_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0; stat_q <= '0; irq <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= (stat_q & ~clr) | evt;
      irq     <= |(stat_q & mask_q);
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [1:0] code;
    if (n < HALF) begin : g_lo
      assign code = clo_q[2*n +: 2];
    end else begin : g_hi
      assign code = chi_q[2*(n-HALF) +: 2];
    end
    assign evt[n] = both_q[n]      ? (sync2_q[n] ^ prev_q[n]) :
                    (code == 2'b00) ? ~sync2_q[n] :
                    (code == 2'b01) ?  sync2_q[n] :
                    (code == 2'b10) ? (sync2_q[n] & ~prev_q[n]) :
                                      (~sync2_q[n] & prev_q[n]);
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = sync2_q;
      A_CLO:   bus_rdata = clo_q;
      A_CHI:   bus_rdata = chi_q;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = stat_q;
      default: bus_rdata = both_q;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] mask,
  input logic [NPIN-1:0] evt
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0 && !irq && stat == '0 && mask == '0));

  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd1) |=> (pad_oe == $past(bus_wdata)));

  a_r2_out_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd0) |=> (pad_out == $past(bus_wdata)));

  a_r6_status_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

  a_r8_clear_unless_event: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd6) |=>
      ((stat & $past(bus_wdata)) == ($past(evt) & $past(bus_wdata))));

  a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(stat) & $past(mask))));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .stat(stat_q), .mask(mask_q), .evt(evt)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic irq;
  int checks = 0, fails = 0;
  bit live = 0;

  always #4 clk = ~clk;

  gpio_irq_port dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // Behavioural reference
  logic [31:0] m_reg [8];
  logic [31:0] pipe [$];   // {previous, synchronised, first stage}
  bit m_irq;

  function automatic logic [31:0] mread(logic [2:0] a);
    return (a == 3'd2) ? pipe[1] : m_reg[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      pipe = '{32'd0, 32'd0, 32'd0};
      m_irq = 0;
    end else begin
      logic [31:0] ev;
      ev = '0;
      for (int n = 0; n < 32; n++) begin
        logic [1:0] c;
        logic now, was;
        c = (n < 16) ? m_reg[3][2*n +: 2] : m_reg[4][2*(n-16) +: 2];
        now = pipe[1][n]; was = pipe[0][n];
        if (m_reg[7][n]) ev[n] = now != was;
        else case (c)
          2'b00: ev[n] = !now;
          2'b01: ev[n] = now;
          2'b10: ev[n] = now && !was;
          default: ev[n] = !now && was;
        endcase
      end
      m_irq = |(m_reg[6] & m_reg[5]);
      if (bus_sel && bus_we && bus_addr == 3'd6) m_reg[6] = m_reg[6] & ~bus_wdata;
      else if (bus_sel && bus_we && bus_addr != 3'd2) m_reg[bus_addr] = bus_wdata;
      m_reg[6] = m_reg[6] | ev;
      void'(pipe.pop_front());
      pipe.push_back(pad_in);
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2 pad_out", pad_out, m_reg[0]);
    chk("R2 pad_oe", pad_oe, m_reg[1]);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    chk(bus_addr == 3'd6 ? "R8 status read" : "R3 read data", bus_rdata, mread(bus_addr));
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1; bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1; bus_sel = 0; bus_we = 0;
  endtask

  task automatic rdm(logic [2:0] a, logic [31:0] m, logic [31:0] e, string tag);
    @(negedge clk); #1; bus_addr = a;
    @(negedge clk); chk(tag, bus_rdata & m, e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); #1; bus_addr = a[2:0];
      @(negedge clk); chk("R1 reset read", bus_rdata, '0);
    end
    chk("R1 reset outputs", pad_out | pad_oe, '0);
    chk("R1 reset irq", {31'd0, irq}, '0);
    #1; rst_n = 1; live = 1;

    wr(3'd1, 32'hF0F0_00FF);
    wr(3'd0, 32'h1234_5678);
    rdm(3'd0, '1, 32'h1234_5678, "R3 data readback");
    rdm(3'd1, '1, 32'hF0F0_00FF, "R3 direction readback");
    chk("R2 pad_out level", pad_out, 32'h1234_5678);
    chk("R2 pad_oe enable", pad_oe, 32'hF0F0_00FF);

    wr(3'd3, 32'hAAAA_AAAA);
    wr(3'd4, 32'hAAAA_AAAA);
    rdm(3'd4, '1, 32'hAAAA_AAAA, "R3 high config readback");
    wr(3'd6, '1);
    idle(3);
    rdm(3'd6, '1, 32'h0, "R6 no event while still");
    pad_in = 32'h1; idle(4);
    rdm(3'd6, 32'h1, 32'h1, "R6 rising sets status");
    wr(3'd6, 32'h1); pad_in = 32'h0; idle(4);
    rdm(3'd6, 32'h1, 32'h0, "R6 falling ignored by rising pin");

    wr(3'd3, 32'hAAAA_AAAB);
    pad_in = 32'h1; idle(4);
    rdm(3'd6, 32'h1, 32'h0, "R4 falling code ignores rise");
    pad_in = 32'h0; idle(4);
    rdm(3'd6, 32'h1, 32'h1, "R4 falling code sets on fall");

    wr(3'd4, 32'hAAAA_AAA6);
    pad_in = 32'h0002_0000; idle(4);
    rdm(3'd6, 32'h0002_0000, 32'h0002_0000, "R4 high level on pin 17");
    rdm(3'd2, '1, 32'h0002_0000, "R10 pad status read");
    wr(3'd6, 32'h0002_0000);
    rdm(3'd6, 32'h0002_0000, 32'h0002_0000, "R8 event wins over clear");
    rdm(3'd6, 32'h0002_0000, 32'h0002_0000, "R5 level keeps setting");
    pad_in = 32'h0; idle(4);
    wr(3'd6, 32'h0002_0000);
    rdm(3'd6, 32'h0002_0000, 32'h0, "R8 clear sticks once level gone");

    wr(3'd7, 32'h20);
    pad_in = 32'h20; idle(4);
    rdm(3'd6, 32'h20, 32'h20, "R7 both-edge rise");
    wr(3'd6, 32'h20); pad_in = 32'h0; idle(4);
    rdm(3'd6, 32'h20, 32'h20, "R7 both-edge fall overrides code");

    wr(3'd5, 32'h20); idle(2);
    chk("R9 irq for unmasked pending pin", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h20); idle(2);
    chk("R9 masked pending pin 0 gives no irq", {31'd0, irq}, 32'd0);

    wr(3'd2, '1);
    rdm(3'd2, '1, 32'h0, "R10 write to pad status ignored");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      pad_in ^= $urandom & $urandom & $urandom;
      bus_sel = ($urandom % 6) == 0;
      bus_we = $urandom % 2;
      bus_addr = $urandom % 8;
      bus_wdata = $urandom;
    end
    @(negedge clk); #1; bus_sel = 0; bus_we = 0;
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule